// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Raw Baud Divider

This block is a full-duplex asynchronous serial port (one start bit, eight data bits sent least significant first, one stop bit, no parity) attached to a 32-bit memory-mapped bus through a small register window. Software programs the bit period as a plain count of system clock cycles in a divider register. It sends a byte by writing the data register and collects the most recent received byte by reading the same register. The transmit and receive pins go straight to the chip pads.

The bus carries no wait-state handshake beyond `bus_ready`. Reads and divider writes complete in the cycle they are presented. A data write presented while a frame is still going out holds `bus_ready` low until the transmitter returns to idle, and is accepted in that cycle. The receive side keeps one byte. A new byte replaces an unread one. A read of the data register when no byte is held returns all ones.

Both directions are driven by four-state machines. The transmitter has the states TX_IDLE, TX_START, TX_DATA and TX_STOP, with these transitions: TX_IDLE to TX_START on an accepted data write; TX_START to TX_DATA after one bit period; TX_DATA to itself per bit and to TX_STOP after the eighth bit; TX_STOP to TX_IDLE after one bit period. The receiver has the states RX_IDLE, RX_START, RX_DATA and RX_STOP, with these transitions: RX_IDLE to RX_START on a low synchronized line; RX_START to RX_DATA if the line is still low at half a bit period, or back to RX_IDLE if it is not (a false start); RX_DATA to itself per bit and to RX_STOP after the eighth bit; RX_STOP to RX_IDLE one bit period later, which also loads the receive buffer.

Top module: `mmio_uart`

## Requirements
- R1: During and after reset `ser_tx` is high, the divider reads back the default value `DIV_RESET` (16), and `ser_tx` stays high whenever the transmitter is idle.
- R2: The divider is at word offset 0. A write sets exactly the bytes whose `bus_wstrb` bit is set (bit n selects data bits 8n+7..8n), and a read returns the full 32-bit value.
- R3: A write with any strobe bit set to word offset 1 sends the low data byte as a frame. The frame is a low start bit, eight data bits least significant first, and a high stop bit, and each bit lasts exactly as many clock cycles as the divider holds.
- R4: A data write presented while a frame is in progress sees `bus_ready` low. It is accepted in the first cycle after the transmitter returns to idle, which is 10 × divider cycles after the previous write was accepted.
- R5: A read of word offset 1 (all strobes zero) while a byte is held returns that byte zero-extended to 32 bits and empties the buffer.
- R6: A read of word offset 1 while the buffer is empty returns 0xFFFFFFFF.
- R7: A byte received while an earlier byte is still unread replaces it.
- R8: The receiver checks the start bit at half a bit period after the falling edge. A low pulse shorter than that is ignored and leaves the buffer empty.
- R9: Word offsets 2 and 3 read as zero and complete at once. Writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access request |
| bus_addr | input | ADDR_W (2) | Word offset within the register window |
| bus_wstrb | input | DATA_W/8 (4) | Byte write strobes; all zero means read |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid while `bus_valid` is high for a read |
| bus_ready | output | 1 | Access completes at the next clock edge when high |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line (asynchronous) |

## Verification
The hardest situations to reach from the ports are the ones where timing on the serial line matters: a second byte arriving before the first is read, and a start pulse that ends before the half-bit check. The bench drives `ser_rx` bit by bit, aligned to the clock. It sends two complete frames back to back without a bus read between them, and it sends a two-cycle low pulse with a 16-cycle bit period, so the receiver enters RX_START and must drop back to RX_IDLE. The transmit stall is reached by issuing a second data write right after the first is accepted. The bench then counts the cycles `bus_ready` stays low.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    localparam int unsigned OFS_DIV  = 0;
    localparam int unsigned OFS_DATA = 1;

endpackage

// File: rtl/mmio_uart_divreg.sv
module mmio_uart_divreg #(
    parameter int unsigned         DATA_W    = 32,
    parameter logic [DATA_W-1:0]   RESET_VAL = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W/8-1:0]   we,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     q
);
    localparam int unsigned LANES = DATA_W / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[l*8 +: 8] <= RESET_VAL[l*8 +: 8];
            end else if (we[l]) begin
                q[l*8 +: 8] <= wdata[l*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx
    import mmio_uart_pkg::*;
#(
    parameter int unsigned DIV_W     = 32,
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIV_W-1:0]      div_i,
    input  logic                  load_i,
    input  logic [DATA_BITS-1:0]  byte_i,
    output logic                  busy_o,
    output logic                  txd_o
);
    localparam int unsigned IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    tx_state_e              state_q, state_n;
    logic [DIV_W-1:0]       cnt_q, cnt_n;
    logic [IDX_W-1:0]       idx_q, idx_n;
    logic [DATA_BITS-1:0]   sh_q, sh_n;
    logic [DIV_W:0]         cnt_inc;
    logic                   bit_end;

    assign cnt_inc = {1'b0, cnt_q} + (DIV_W+1)'(1);
    // a divider of 0 or 1 gives one cycle per bit, never a stuck counter
    assign bit_end = cnt_inc >= {1'b0, div_i};

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        idx_n   = idx_q;
        sh_n    = sh_q;
        unique case (state_q)
            TX_IDLE: begin
                if (load_i) begin
                    state_n = TX_START;
                    cnt_n   = '0;
                    sh_n    = byte_i;
                end
            end
            TX_START: begin
                if (bit_end) begin
                    state_n = TX_DATA;
                    cnt_n   = '0;
                    idx_n   = '0;
                end else begin
                    cnt_n = cnt_inc[DIV_W-1:0];
                end
            end
            TX_DATA: begin
                if (bit_end) begin
                    cnt_n = '0;
                    sh_n  = sh_q >> 1;
                    if (idx_q == LAST_IDX) begin
                        state_n = TX_STOP;
                    end else begin
                        idx_n = idx_q + IDX_W'(1);
                    end
                end else begin
                    cnt_n = cnt_inc[DIV_W-1:0];
                end
            end
            TX_STOP: begin
                if (bit_end) begin
                    state_n = TX_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_inc[DIV_W-1:0];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            idx_q   <= idx_n;
            sh_q    <= sh_n;
        end
    end

    always_comb begin
        unique case (state_q)
            TX_IDLE:  begin txd_o = 1'b1;    busy_o = 1'b0; end
            TX_START: begin txd_o = 1'b0;    busy_o = 1'b1; end
            TX_DATA:  begin txd_o = sh_q[0]; busy_o = 1'b1; end
            TX_STOP:  begin txd_o = 1'b1;    busy_o = 1'b1; end
        endcase
    end

endmodule

// File: rtl/mmio_uart_rx.sv
module mmio_uart_rx
    import mmio_uart_pkg::*;
#(
    parameter int unsigned DIV_W       = 32,
    parameter int unsigned DATA_BITS   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIV_W-1:0]      div_i,
    input  logic                  rxd_i,
    output logic                  done_o,
    output logic [DATA_BITS-1:0]  byte_o
);
    localparam int unsigned IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;

    // metastability chain; idles high like the line
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q[s] <= 1'b1;
            end else if (s == 0) begin
                sync_q[s] <= rxd_i;
            end else begin
                sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
            end
        end
    end
    assign rx_s = sync_q[SYNC_STAGES-1];

    rx_state_e              state_q, state_n;
    logic [DIV_W-1:0]       cnt_q, cnt_n;
    logic [IDX_W-1:0]       idx_q, idx_n;
    logic [DATA_BITS-1:0]   sh_q, sh_n;
    logic [DIV_W:0]         cnt_inc;
    logic [DIV_W-1:0]       half_div;
    logic                   half_end, bit_end;

    assign cnt_inc  = {1'b0, cnt_q} + (DIV_W+1)'(1);
    assign half_div = div_i >> 1;
    assign half_end = cnt_inc >= {1'b0, half_div};
    assign bit_end  = cnt_inc >= {1'b0, div_i};

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        idx_n   = idx_q;
        sh_n    = sh_q;
        unique case (state_q)
            RX_IDLE: begin
                if (!rx_s) begin
                    state_n = RX_START;
                    cnt_n   = '0;
                end
            end
            RX_START: begin
                if (half_end) begin
                    cnt_n   = '0;
                    idx_n   = '0;
                    state_n = rx_s ? RX_IDLE : RX_DATA;
                end else begin
                    cnt_n = cnt_inc[DIV_W-1:0];
                end
            end
            RX_DATA: begin
                if (bit_end) begin
                    cnt_n = '0;
                    sh_n  = {rx_s, sh_q[DATA_BITS-1:1]};
                    if (idx_q == LAST_IDX) begin
                        state_n = RX_STOP;
                    end else begin
                        idx_n = idx_q + IDX_W'(1);
                    end
                end else begin
                    cnt_n = cnt_inc[DIV_W-1:0];
                end
            end
            RX_STOP: begin
                if (bit_end) begin
                    state_n = RX_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_inc[DIV_W-1:0];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            idx_q   <= idx_n;
            sh_q    <= sh_n;
        end
    end

    always_comb begin
        unique case (state_q)
            RX_IDLE, RX_START, RX_DATA: done_o = 1'b0;
            RX_STOP:                    done_o = bit_end;
        endcase
        byte_o = sh_q;
    end

endmodule

// File: rtl/mmio_uart_rxbuf.sv
module mmio_uart_rxbuf #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  done_i,
    input  logic [DATA_BITS-1:0]  byte_i,
    input  logic                  pop_i,
    output logic                  full_o,
    output logic [DATA_W-1:0]     data_o
);
    logic [DATA_BITS-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            hold_q <= '0;
        end else if (done_i) begin
            full_o <= 1'b1;
            hold_q <= byte_i;
        end else if (pop_i) begin
            full_o <= 1'b0;
        end
    end

    assign data_o = full_o ? {{(DATA_W-DATA_BITS){1'b0}}, hold_q} : '1;

endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
    import mmio_uart_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DIV_RESET = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W/8-1:0]   bus_wstrb,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_ready,
    output logic                  ser_tx,
    input  logic                  ser_rx
);
    localparam int unsigned STRB_W    = DATA_W / 8;
    localparam int unsigned DATA_BITS = 8;

    logic                  hit_div, hit_dat, is_write;
    logic [STRB_W-1:0]     div_we;
    logic [DATA_W-1:0]     div_q;
    logic                  tx_load, tx_busy;
    logic                  rx_done, rx_pop, rx_full;
    logic [DATA_BITS-1:0]  rx_byte;
    logic [DATA_W-1:0]     rx_word;

    assign is_write = |bus_wstrb;
    assign hit_div  = bus_valid && (bus_addr == ADDR_W'(OFS_DIV));
    assign hit_dat  = bus_valid && (bus_addr == ADDR_W'(OFS_DATA));
    assign div_we   = hit_div ? bus_wstrb : '0;
    assign tx_load  = hit_dat && is_write && !tx_busy;
    assign rx_pop   = hit_dat && !is_write;

    always_comb begin
        bus_ready = !(hit_dat && is_write && tx_busy);
        bus_rdata = '0;
        if (hit_div && !is_write) begin
            bus_rdata = div_q;
        end else if (hit_dat && !is_write) begin
            bus_rdata = rx_word;
        end
    end

    mmio_uart_divreg #(
        .DATA_W   (DATA_W),
        .RESET_VAL(DATA_W'(DIV_RESET))
    ) u_divreg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (div_we),
        .wdata(bus_wdata),
        .q    (div_q)
    );

    mmio_uart_tx #(
        .DIV_W    (DATA_W),
        .DATA_BITS(DATA_BITS)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .div_i (div_q),
        .load_i(tx_load),
        .byte_i(bus_wdata[DATA_BITS-1:0]),
        .busy_o(tx_busy),
        .txd_o (ser_tx)
    );

    mmio_uart_rx #(
        .DIV_W      (DATA_W),
        .DATA_BITS  (DATA_BITS),
        .SYNC_STAGES(2)
    ) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .div_i (div_q),
        .rxd_i (ser_rx),
        .done_o(rx_done),
        .byte_o(rx_byte)
    );

    mmio_uart_rxbuf #(
        .DATA_W   (DATA_W),
        .DATA_BITS(DATA_BITS)
    ) u_rxbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .done_i(rx_done),
        .byte_i(rx_byte),
        .pop_i (rx_pop),
        .full_o(rx_full),
        .data_o(rx_word)
    );

endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W/8-1:0]  bus_wstrb,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 bus_ready,
    input logic                 ser_tx,
    input logic                 tx_busy,
    input logic                 rx_full,
    input logic                 rx_done,
    input logic [DATA_W-1:0]    div_q
);
    localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(1);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> ser_tx);

    // R3
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !ser_tx);

    // R4
    stall_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr == A_DAT && |bus_wstrb && tx_busy) |-> !bus_ready);

    // R4
    load_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_addr == A_DAT && |bus_wstrb) |=> tx_busy);

    // R2
    div_read_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr == A_DIV && bus_wstrb == '0) |=> $stable(div_q));

    // R6
    empty_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr == A_DAT && bus_wstrb == '0 && !rx_full)
        |-> (bus_rdata == '1));

    // R5
    read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr == A_DAT && bus_wstrb == '0 && !rx_done) |=> !rx_full);

    // R9
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr > A_DAT) |-> (bus_ready && bus_rdata == '0));

    // R9
    unmapped_keeps_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr > A_DAT) |=> $stable(div_q));

endmodule

bind mmio_uart mmio_uart_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_addr (bus_addr),
    .bus_wstrb(bus_wstrb),
    .bus_rdata(bus_rdata),
    .bus_ready(bus_ready),
    .ser_tx   (ser_tx),
    .tx_busy  (tx_busy),
    .rx_full  (rx_full),
    .rx_done  (rx_done),
    .div_q    (div_q)
);

// File: tb/mmio_uart_bench.sv
module mmio_uart_bench;
    localparam int DW      = 32;
    localparam int AW      = 2;
    localparam int DEF_DIV = 16;
    localparam int NVEC    = 6;
    // {bit period in cycles, byte}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'd4,  8'h55}, {8'd5,  8'hA3}, {8'd8,  8'h00},
        {8'd6,  8'hFF}, {8'd7,  8'h81}, {8'd10, 8'h3C}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bus_valid;
    logic [AW-1:0]   bus_addr;
    logic [DW/8-1:0] bus_wstrb;
    logic [DW-1:0]   bus_wdata;
    logic [DW-1:0]   bus_rdata;
    logic            bus_ready;
    logic            ser_tx;
    logic            ser_rx;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mmio_uart u_mmio_uart (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_addr (bus_addr),
        .bus_wstrb(bus_wstrb),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_ready(bus_ready),
        .ser_tx   (ser_tx),
        .ser_rx   (ser_rx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called just after a negedge; returns just after a negedge
    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d,
                             input logic [3:0] s, output int waits);
        bus_valid = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        waits = 0;
        forever begin
            #1;
            if (bus_ready) break;
            waits++;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_wstrb = '0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d,
                            output logic rdy);
        bus_valid = 1'b1; bus_addr = a; bus_wstrb = '0;
        #1;
        d = bus_rdata;
        rdy = bus_ready;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // starts at the first negedge after the load edge
    task automatic capture_tx(input int div, output logic [9:0] frame);
        int pos = 0;
        for (int i = 0; i < 10; i++) begin
            int tgt = i*div + div/2;
            repeat (tgt - pos) @(negedge clk);
            pos = tgt;
            frame[i] = ser_tx;
        end
        repeat (10*div - pos) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input int div);
        logic [9:0] f = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            ser_rx = f[i];
            repeat (div) @(negedge clk);
        end
        ser_rx = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic        rdy;
        logic [9:0]  frame;
        int          w;
        int          dv;

        rst_n = 1'b0; bus_valid = 1'b0; bus_addr = '0;
        bus_wstrb = '0; bus_wdata = '0; ser_rx = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 tx high in reset", 32'(ser_tx), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx high after reset", 32'(ser_tx), 32'd1);
        bus_read(2'd0, rd, rdy);
        check("R1 divider default", rd, DEF_DIV);
        bus_read(2'd1, rd, rdy);
        check("R6 empty read after reset", rd, 32'hFFFF_FFFF);

        // table walk: program divider, send a frame, receive a frame
        for (int v = 0; v < NVEC; v++) begin
            dv = int'(VEC[v][15:8]);
            bus_write(2'd0, 32'(dv), 4'hF, w);
            bus_read(2'd0, rd, rdy);
            check("R2 divider readback", rd, 32'(dv));
            bus_write(2'd1, {24'hABCDEF, VEC[v][7:0]}, 4'h1, w);
            capture_tx(dv, frame);
            check("R3 tx frame", 32'(frame), 32'({1'b1, VEC[v][7:0], 1'b0}));
            check("R1 idle after frame", 32'(ser_tx), 32'd1);
            send_rx(VEC[v][7:0], dv);
            repeat (dv + 4) @(negedge clk);
            bus_read(2'd1, rd, rdy);
            check("R5 rx byte zero-extended", rd, {24'h0, VEC[v][7:0]});
            bus_read(2'd1, rd, rdy);
            check("R6 buffer emptied by read", rd, 32'hFFFF_FFFF);
        end

        // R2 byte strobes
        bus_write(2'd0, 32'h1122_3344, 4'hF, w);
        bus_write(2'd0, 32'hAABB_CCDD, 4'h5, w);
        bus_read(2'd0, rd, rdy);
        check("R2 partial strobe", rd, 32'h11BB_33DD);

        // R9 unmapped offsets
        bus_write(2'd0, 32'd6, 4'hF, w);
        bus_write(2'd2, 32'hDEAD_BEEF, 4'hF, w);
        check("R9 unmapped write no wait", 32'(w), 32'd0);
        bus_write(2'd3, 32'h0000_0001, 4'hF, w);
        bus_read(2'd2, rd, rdy);
        check("R9 unmapped reads zero", rd, 32'd0);
        bus_read(2'd0, rd, rdy);
        check("R9 divider untouched", rd, 32'd6);
        bus_read(2'd1, rd, rdy);
        check("R9 rx buffer untouched", rd, 32'hFFFF_FFFF);

        // R4 back-to-back writes stall for a full frame
        bus_write(2'd1, 32'h0000_005A, 4'h1, w);
        bus_write(2'd1, 32'h0000_00C3, 4'h1, w);
        check("R4 stall cycles", 32'(w), 32'(10*6));
        capture_tx(6, frame);
        check("R4 second frame sent", 32'(frame), 32'({1'b1, 8'hC3, 1'b0}));

        // R7 overwrite of unread byte
        send_rx(8'h12, 6);
        send_rx(8'h34, 6);
        repeat (10) @(negedge clk);
        bus_read(2'd1, rd, rdy);
        check("R7 newest byte kept", rd, 32'h0000_0034);

        // R8 short low pulse is a false start
        bus_write(2'd0, 32'd16, 4'hF, w);
        ser_rx = 1'b0;
        repeat (2) @(negedge clk);
        ser_rx = 1'b1;
        repeat (200) @(negedge clk);
        bus_read(2'd1, rd, rdy);
        check("R8 glitch ignored", rd, 32'hFFFF_FFFF);
        send_rx(8'h96, 16);
        repeat (20) @(negedge clk);
        bus_read(2'd1, rd, rdy);
        check("R8 receiver recovers", rd, 32'h0000_0096);

        finish_run();
    end

endmodule